// File: doc/BRIEF.md
# Enable-Gated Three-Wire Word Loader

This block takes a control word from a host microcontroller over a three-wire serial bus made of data, bus clock and enable lines. All three lines, and the static word-length select, are brought into the system clock domain through two-flop synchronisers. Edges are then found by comparing each synchronised line with its value one cycle earlier. The system clock must run at least eight times as fast as the bus clock. Bits enter a shift register on rising bus-clock edges, and only while enable is high. Bus-clock activity while enable is low has no effect at all.

When enable falls, the most recent bits shifted in are decoded into a divisor value and four port bits, and both are copied into holding registers. The outputs change only at that moment, so the active divisor is never a half-loaded word. The word-length select chooses between two formats. With the select high, the word is 18 bits and carries a 14-bit divisor. With the select low, the word is 19 bits and carries a 15-bit divisor. In both formats the divisor comes first, most significant bit first, and the four port bits come last.

A small state machine sequences the transfer. It has three states: `ST_IDLE` (enable low, bus clock ignored), `ST_SHIFT` (enable high, shifting on bus-clock rises) and `ST_COMMIT` (one cycle in which the holding registers may load). The transitions are:

- `idle_to_shift`: from `ST_IDLE` when the synchronised enable is high. The bit counter clears on this transition.
- `shift_to_commit`: from `ST_SHIFT` when the synchronised enable is low.
- `commit_to_idle`: from `ST_COMMIT`, taken unconditionally.

Top module: `tw_word_loader`

## Requirements
- R1: While enable is high, each rising edge of the bus clock shifts the current data bit into the word, most significant bit first.
- R2: Bus-clock edges while enable is low change neither the outputs nor the next word decoded.
- R3: The divisor and port outputs keep their previous values for the whole time enable is high, and for at least the first system cycle after enable falls.
- R4: With `mode_short_i` high, the word is 18 bits. `divisor_o[13:0]` takes the first 14 bits and `divisor_o[14]` is 0.
- R5: With `mode_short_i` low, the word is 19 bits and `divisor_o[14:0]` takes the first 15 bits.
- R6: The last four bits of the word go to the ports in arrival order: the first of the four goes to `port_o[3]` and the last goes to `port_o[0]`.
- R7: If more bits than the word length arrive in one enable-high window, only the most recent word-length bits are used.
- R8: If fewer bits than the word length arrive in one enable-high window, both outputs keep their previous values.
- R9: After reset, `divisor_o` is 0 and `port_o` is 0.
- R10: New output values appear no later than 6 system clock cycles after enable falls at the input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Serial bus clock from the host |
| bus_dat_i | input | 1 | Serial data from the host |
| bus_en_i | input | 1 | Enable from the host; high frames a word |
| mode_short_i | input | 1 | High selects the 18-bit word, low selects the 19-bit word |
| divisor_o | output | 15 | Committed divisor value |
| port_o | output | 4 | Committed port bits |

## Verification
The bench sends words that are longer than the word length, shorter than it, and exactly that length, in both formats. A design that kept the oldest bits would decode the wrong divisor on an over-length word. A design that committed a short word would corrupt the outputs when it should have left them unchanged. The bench also toggles the bus clock while enable is low, then sends a full word, which shows whether stray edges slipped into the shift register. Throughout the word it watches the outputs, which catches any design that updates them before enable falls.

// File: rtl/tw_loader_pkg.sv
package tw_loader_pkg;
    localparam int unsigned DIV_W_SHORT = 14;
    localparam int unsigned DIV_W_LONG  = 15;
    localparam int unsigned PORT_W      = 4;
    localparam int unsigned WORD_SHORT  = DIV_W_SHORT + PORT_W;
    localparam int unsigned WORD_LONG   = DIV_W_LONG + PORT_W;
    localparam int unsigned CNT_W       = $clog2(WORD_LONG + 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ld_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // One independent two-flop chain per input line.
    for (genvar g = 0; g < WIDTH; g++) begin : g_chain
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stage1_q[g] <= 1'b0;
                stage2_q[g] <= 1'b0;
            end else begin
                stage1_q[g] <= async_i[g];
                stage2_q[g] <= stage1_q[g];
            end
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter
    import tw_loader_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 clear_i,
    input  logic                 shift_i,
    input  logic                 bit_i,
    output logic [WORD_LONG-1:0] word_o,
    output logic [CNT_W-1:0]     count_o
);
    logic [WORD_LONG-1:0] sr_q;
    logic [CNT_W-1:0]     cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (shift_i) begin
            sr_q <= {sr_q[WORD_LONG-2:0], bit_i};
            // Saturate: once a full long word is in, older bits drop off the top.
            if (cnt_q != CNT_W'(WORD_LONG)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign word_o  = sr_q;
    assign count_o = cnt_q;

    // R2: the register only moves when the controller asks it to.
    a_r2_hold_without_shift : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_i |=> $stable(sr_q));

    // R7: the count never exceeds the longest word.
    a_r7_count_bounded : assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_W'(WORD_LONG));
endmodule

// File: rtl/tw_loader_fsm.sv
module tw_loader_fsm
    import tw_loader_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  en_s_i,
    input  logic                  bclk_s_i,
    input  logic                  mode_s_i,
    input  logic [WORD_LONG-1:0]  word_i,
    input  logic [CNT_W-1:0]      count_i,
    output logic                  clear_o,
    output logic                  shift_o,
    output logic [DIV_W_LONG-1:0] divisor_o,
    output logic [PORT_W-1:0]     port_o
);
    ld_state_e state_q, state_d;
    logic      bclk_prev_q;
    logic      bclk_rise;
    logic      enough;
    logic      load;

    logic [DIV_W_LONG-1:0] div_q, div_d;
    logic [PORT_W-1:0]     port_q, port_d;

    assign bclk_rise = bclk_s_i & ~bclk_prev_q;

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            bclk_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            bclk_prev_q <= bclk_s_i;
        end
    end

    // Next state and datapath controls.
    always_comb begin
        state_d = state_q;
        clear_o = 1'b0;
        shift_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_s_i) begin
                    state_d = ST_SHIFT;
                    clear_o = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (!en_s_i) begin
                    state_d = ST_COMMIT;
                end else begin
                    shift_o = bclk_rise;
                end
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Decode of the held word and holding-register next values.
    assign enough = mode_s_i ? (count_i >= CNT_W'(WORD_SHORT))
                             : (count_i >= CNT_W'(WORD_LONG));
    assign load   = (state_q == ST_COMMIT) && enough;

    always_comb begin
        div_d  = div_q;
        port_d = port_q;
        if (load) begin
            port_d = word_i[PORT_W-1:0];
            if (mode_s_i) begin
                div_d = {{(DIV_W_LONG-DIV_W_SHORT){1'b0}},
                         word_i[WORD_SHORT-1:PORT_W]};
            end else begin
                div_d = word_i[WORD_LONG-1:PORT_W];
            end
        end
    end

    // Output (holding) registers.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q  <= '0;
            port_q <= '0;
        end else begin
            div_q  <= div_d;
            port_q <= port_d;
        end
    end

    assign divisor_o = div_q;
    assign port_o    = port_q;

    // R3: outside the commit state the outputs do not move.
    a_r3_hold_outside_commit : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_COMMIT) |=> ($stable(div_q) && $stable(port_q)));

    // R8: a short word leaves the outputs alone.
    a_r8_short_word_kept : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_COMMIT && !enough) |=> ($stable(div_q) && $stable(port_q)));

    // R4: the short format never sets the top divisor bit.
    a_r4_short_msb_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_COMMIT && enough && mode_s_i) |=> (div_q[DIV_W_LONG-1] == 1'b0));

    // R1: commit is only reached from shifting.
    a_r1_commit_from_shift : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_COMMIT) |-> ($past(state_q) == ST_SHIFT));

    // R2: no shifting outside the shift state.
    a_r2_no_shift_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_SHIFT) |-> !shift_o);
endmodule

// File: rtl/tw_word_loader.sv
module tw_word_loader
    import tw_loader_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bus_clk_i,
    input  logic                  bus_dat_i,
    input  logic                  bus_en_i,
    input  logic                  mode_short_i,
    output logic [DIV_W_LONG-1:0] divisor_o,
    output logic [PORT_W-1:0]     port_o
);
    localparam int unsigned N_LINES = 4;

    logic [N_LINES-1:0]   raw;
    logic [N_LINES-1:0]   synced;
    logic                 clear;
    logic                 shift;
    logic [WORD_LONG-1:0] word;
    logic [CNT_W-1:0]     count;

    assign raw = {mode_short_i, bus_en_i, bus_clk_i, bus_dat_i};

    tw_sync #(.WIDTH(N_LINES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw),
        .sync_o  (synced)
    );

    tw_shifter u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear),
        .shift_i (shift),
        .bit_i   (synced[0]),
        .word_o  (word),
        .count_o (count)
    );

    tw_loader_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_s_i    (synced[2]),
        .bclk_s_i  (synced[1]),
        .mode_s_i  (synced[3]),
        .word_i    (word),
        .count_i   (count),
        .clear_o   (clear),
        .shift_o   (shift),
        .divisor_o (divisor_o),
        .port_o    (port_o)
    );
endmodule

// File: tb/tw_word_loader_tb.sv
module tw_word_loader_tb_top;
    logic        clk;
    logic        rst_n;
    logic        bclk;
    logic        bdat;
    logic        ben;
    logic        mode_s;
    logic [14:0] div_o;
    logic [3:0]  port_o;

    int unsigned n_tests;
    int unsigned n_fail;
    bit          done;

    logic [63:0] hist;
    int          hist_n;
    logic [14:0] exp_div;
    logic [3:0]  exp_port;

    tw_word_loader dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .bus_clk_i    (bclk),
        .bus_dat_i    (bdat),
        .bus_en_i     (ben),
        .mode_short_i (mode_s),
        .divisor_o    (div_o),
        .port_o       (port_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Work out the expected outputs from the bits seen in one window.
    function automatic void model_commit(input logic mode_short);
        int need;
        need = mode_short ? 18 : 19;
        if (hist_n >= need) begin
            exp_port = hist[3:0];
            if (mode_short) exp_div = {1'b0, hist[17:4]};
            else            exp_div = hist[18:4];
        end
    endfunction

    // Send n bits, MSB first taken from bits[n-1]; returns after enable fall + settle.
    task automatic send_word(input int n, input logic [63:0] bits, input string req);
        logic [14:0] old_div;
        logic [3:0]  old_port;
        old_div  = div_o;
        old_port = port_o;
        hist   = '0;
        hist_n = 0;
        ben = 1'b1;
        wait_cyc(6);
        for (int i = n - 1; i >= 0; i--) begin
            bdat = bits[i];
            hist = {hist[62:0], bits[i]};
            hist_n++;
            wait_cyc(4);
            bclk = 1'b1;
            wait_cyc(8);
            bclk = 1'b0;
            wait_cyc(4);
        end
        // R3: nothing changed while enable was high.
        check({"R3 ", req, " mid-word"}, {port_o, div_o}, {old_port, old_div});
        ben = 1'b0;
        wait_cyc(1);
        check({"R3 ", req, " just after fall"}, {port_o, div_o}, {old_port, old_div});
        wait_cyc(5); // R10: 6 cycles after the fall
        model_commit(mode_s);
        check({"R10 ", req}, {port_o, div_o}, {exp_port, exp_div});
        wait_cyc(4);
    endtask

    task automatic set_mode(input logic m);
        mode_s = m;
        wait_cyc(6);
    endtask

    initial begin
        n_tests = 0;
        n_fail  = 0;
        done    = 1'b0;
        exp_div = '0;
        exp_port = '0;
        hist = '0;
        hist_n = 0;
        rst_n = 1'b0;
        bclk = 1'b0;
        bdat = 1'b0;
        ben = 1'b0;
        mode_s = 1'b0;
        void'($urandom(32'd1234));
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);

        // R9: reset state.
        check("R9 reset", {port_o, div_o}, 19'h0);

        // R5 / R6 / R1: long format directed, divisor 0x5A3C, ports 1011.
        set_mode(1'b0);
        send_word(19, {45'b0, 15'h5A3C, 4'b1011}, "R5 long");
        check("R5 divisor", {4'h0, div_o}, {4'h0, 15'h5A3C});
        check("R6 ports", {15'h0, port_o}, {15'h0, 4'b1011});

        // R4: short format directed, top 14 bits of divisor, MSB of output 0.
        set_mode(1'b1);
        send_word(18, {46'b0, 14'h3FFF, 4'b0110}, "R4 short");
        check("R4 divisor", {4'h0, div_o}, {4'h0, 15'h3FFF});
        check("R6 ports short", {15'h0, port_o}, {15'h0, 4'b0110});

        // R7: over-length in long mode, extra leading ones dropped.
        set_mode(1'b0);
        send_word(23, {41'b0, 4'b1111, 15'h0123, 4'b0001}, "R7 over");
        check("R7 divisor", {4'h0, div_o}, {4'h0, 15'h0123});

        // R8: too short, outputs kept.
        send_word(12, {52'b0, 12'hABC}, "R8 short window");
        check("R8 kept", {port_o, div_o}, {4'b0001, 15'h0123});

        // R2: bus clock toggles with enable low, then a full word.
        bdat = 1'b1;
        for (int k = 0; k < 10; k++) begin
            bclk = 1'b1; wait_cyc(8);
            bclk = 1'b0; wait_cyc(8);
        end
        check("R2 idle clocks", {port_o, div_o}, {4'b0001, 15'h0123});
        set_mode(1'b1);
        send_word(18, {46'b0, 14'h0005, 4'b0100}, "R2 after stray");
        check("R2 word clean", {port_o, div_o}, {4'b0100, 15'h0005});

        // Random mix of modes and lengths.
        for (int t = 0; t < 40; t++) begin
            logic [63:0] bits;
            int          len;
            bits = {$urandom(), $urandom()};
            len  = 10 + int'($urandom_range(0, 14));
            set_mode(1'($urandom_range(0, 1)));
            send_word(len, bits, "R1 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule